// File: doc/BRIEF.md
# Split-Table Gain Decrement Router

This block sits beside the receive gain tables when the gain is split across a limiter stage, a filter stage and a digital stage. Peak detectors on each receive channel raise overload flags. The block turns those flags into a single gain-reduction command per channel per clock. Each command names the table whose index is lowered and the amount to lower it by.

The choice of table follows a fixed priority among the overload types. It also depends on where the limiter index sits relative to a programmable limit, which splits the limiter table into an upper part and a lower part. Limiter gain is always reduced first. Once the limiter index reaches the relevant floor, the overload type decides whether the filter table takes the cut. Digital saturation always goes to the digital table.

The amount of each cut is the programmed step, clamped so that the target index never passes its floor. Index storage, applying the commands and peak detection all live outside this block. Each channel is routed by its own identical copy of the logic. Commands appear one clock after the inputs that cause them.

Top module: `gr_router`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it is released, every cmd_valid_o bit is 0.
- R2: While auto_en_i is low, no command is issued on any channel in the following cycle.
- R3: A channel whose four overload flags are all 0 issues no command.
- R4: A channel's flag nibble holds the large limiter overload at bit 0, the large ADC overload at bit 1, the small ADC overload at bit 2 and digital saturation at bit 3. The priority is limiter over ADC over digital saturation, and lower-priority flags are ignored when a higher one is set. Target codes are 0 for limiter, 1 for filter and 2 for digital; code 3 is never issued.
- R5: With the large limiter overload selected and the limiter index above 0, the target is the limiter. The amount is the smaller of the step and the limiter index.
- R6: With the large limiter overload selected and the limiter index at 0, the target is the filter table. The amount is the smaller of the step and the filter index.
- R7: With an ADC overload (large or small) selected and the limiter index above the limit, the target is the limiter. The amount is the smaller of the step and the limiter index minus the limit.
- R8: With an ADC overload selected and the limiter index at or below the limit, the target is the filter table. The amount is the smaller of the step and the filter index.
- R9: With only digital saturation present, the target is the digital table whatever the other indices hold. The amount is the smaller of the step and the digital index.
- R10: If the table chosen by R5 to R9 has no room left (its clamped amount is 0), the command is suppressed. No lower-priority overload is served in its place.
- R11: A command appears exactly one clock after the inputs that produce it. Each channel depends only on its own flags and indices plus the shared step, limit and enable.
- R12: A step of 0 issues no command on any channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| auto_en_i | input | 1 | Enables overload-directed routing |
| step_i | input | STEP_W | Decrement step setting |
| lmt_limit_i | input | IDX_W | Limiter index limit that splits the upper and lower limiter table |
| ovl_i | input | NUM_CH*4 | Overload flags, one nibble per channel (bit order in R4) |
| lmt_idx_i | input | NUM_CH*IDX_W | Current limiter index per channel |
| lpf_idx_i | input | NUM_CH*IDX_W | Current filter index per channel |
| dig_idx_i | input | NUM_CH*IDX_W | Current digital gain index per channel |
| cmd_valid_o | output | NUM_CH | One-cycle command strobe per channel |
| cmd_tgt_o | output | NUM_CH*2 | Target table code per channel |
| cmd_amt_o | output | NUM_CH*STEP_W | Decrement amount per channel |

## Verification
The assertions assume that flags, indices, limit and step are synchronous to clk_i and stable around each rising edge. The bench meets this by driving every input on the falling edge. The assertions also assume that the limit may take any value, including values at or above the limiter index. The sweep relies on this: with a small index and step width, it walks every flag combination against every limiter index, limit and step, with filter and digital indices that include 0. The second channel receives a permuted pattern in the same cycle, so crosstalk between channels shows up as a mismatch.

// File: rtl/gr_pkg.sv
package gr_pkg;
  localparam int FLAG_W = 4;
  localparam int F_LMT_BIG = 0;
  localparam int F_ADC_BIG = 1;
  localparam int F_ADC_SML = 2;
  localparam int F_DIG_SAT = 3;

  typedef enum logic [1:0] {
    TGT_LMT = 2'd0,
    TGT_LPF = 2'd1,
    TGT_DIG = 2'd2
  } tgt_e;

  typedef enum logic [1:0] {
    OVL_NONE = 2'd0,
    OVL_LMT  = 2'd1,
    OVL_ADC  = 2'd2,
    OVL_DIG  = 2'd3
  } ovl_e;
endpackage

// File: rtl/gr_prio.sv
module gr_prio
  import gr_pkg::*;
(
  input  logic [FLAG_W-1:0] flags_i,
  output ovl_e              cls_o
);
  always_comb begin
    if (flags_i[F_LMT_BIG])                           cls_o = OVL_LMT;
    else if (flags_i[F_ADC_BIG] || flags_i[F_ADC_SML]) cls_o = OVL_ADC;
    else if (flags_i[F_DIG_SAT])                      cls_o = OVL_DIG;
    else                                              cls_o = OVL_NONE;
  end
endmodule

// File: rtl/gr_route.sv
module gr_route
  import gr_pkg::*;
#(
  parameter int IDX_W  = 5,
  parameter int STEP_W = 3
) (
  input  ovl_e              cls_i,
  input  logic [IDX_W-1:0]  lmt_idx_i,
  input  logic [IDX_W-1:0]  lpf_idx_i,
  input  logic [IDX_W-1:0]  dig_idx_i,
  input  logic [IDX_W-1:0]  limit_i,
  input  logic [STEP_W-1:0] step_i,
  output logic              hit_o,
  output tgt_e              tgt_o,
  output logic [STEP_W-1:0] amt_o
);
  localparam int CW = (IDX_W > STEP_W) ? IDX_W : STEP_W;

  logic [IDX_W-1:0] room;
  logic [CW-1:0]    room_x, step_x, amt_x;

  always_comb begin
    tgt_o = TGT_LMT;
    room  = '0;
    unique case (cls_i)
      OVL_LMT: begin
        if (lmt_idx_i != '0) begin
          tgt_o = TGT_LMT;
          room  = lmt_idx_i;
        end else begin
          tgt_o = TGT_LPF;
          room  = lpf_idx_i;
        end
      end
      OVL_ADC: begin
        // upper limiter table first, then filter
        if (lmt_idx_i > limit_i) begin
          tgt_o = TGT_LMT;
          room  = lmt_idx_i - limit_i;
        end else begin
          tgt_o = TGT_LPF;
          room  = lpf_idx_i;
        end
      end
      OVL_DIG: begin
        tgt_o = TGT_DIG;
        room  = dig_idx_i;
      end
      default: begin
        tgt_o = TGT_LMT;
        room  = '0;
      end
    endcase
  end

  assign room_x = CW'(room);
  assign step_x = CW'(step_i);
  assign amt_x  = (step_x > room_x) ? room_x : step_x;
  assign amt_o  = amt_x[STEP_W-1:0];
  assign hit_o  = (cls_i != OVL_NONE) && (amt_x != '0);
endmodule

// File: rtl/gr_chan.sv
module gr_chan
  import gr_pkg::*;
#(
  parameter int IDX_W  = 5,
  parameter int STEP_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [FLAG_W-1:0] flags_i,
  input  logic [IDX_W-1:0]  lmt_idx_i,
  input  logic [IDX_W-1:0]  lpf_idx_i,
  input  logic [IDX_W-1:0]  dig_idx_i,
  input  logic [IDX_W-1:0]  limit_i,
  input  logic [STEP_W-1:0] step_i,
  output logic              valid_o,
  output logic [1:0]        tgt_o,
  output logic [STEP_W-1:0] amt_o
);
  ovl_e              cls;
  logic              hit;
  tgt_e              tgt_d;
  logic [STEP_W-1:0] amt_d;

  gr_prio u_prio (
    .flags_i (flags_i),
    .cls_o   (cls)
  );

  gr_route #(.IDX_W(IDX_W), .STEP_W(STEP_W)) u_route (
    .cls_i     (cls),
    .lmt_idx_i (lmt_idx_i),
    .lpf_idx_i (lpf_idx_i),
    .dig_idx_i (dig_idx_i),
    .limit_i   (limit_i),
    .step_i    (step_i),
    .hit_o     (hit),
    .tgt_o     (tgt_d),
    .amt_o     (amt_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      tgt_o   <= TGT_LMT;
      amt_o   <= '0;
    end else begin
      valid_o <= en_i & hit;
      tgt_o   <= tgt_d;
      amt_o   <= amt_d;
    end
  end
endmodule

// File: rtl/gr_router.sv
module gr_router
  import gr_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int IDX_W  = 5,
  parameter int STEP_W = 3
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       auto_en_i,
  input  logic [STEP_W-1:0]          step_i,
  input  logic [IDX_W-1:0]           lmt_limit_i,
  input  logic [NUM_CH*FLAG_W-1:0]   ovl_i,
  input  logic [NUM_CH*IDX_W-1:0]    lmt_idx_i,
  input  logic [NUM_CH*IDX_W-1:0]    lpf_idx_i,
  input  logic [NUM_CH*IDX_W-1:0]    dig_idx_i,
  output logic [NUM_CH-1:0]          cmd_valid_o,
  output logic [NUM_CH*2-1:0]        cmd_tgt_o,
  output logic [NUM_CH*STEP_W-1:0]   cmd_amt_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    gr_chan #(.IDX_W(IDX_W), .STEP_W(STEP_W)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_i      (auto_en_i),
      .flags_i   (ovl_i[c*FLAG_W +: FLAG_W]),
      .lmt_idx_i (lmt_idx_i[c*IDX_W +: IDX_W]),
      .lpf_idx_i (lpf_idx_i[c*IDX_W +: IDX_W]),
      .dig_idx_i (dig_idx_i[c*IDX_W +: IDX_W]),
      .limit_i   (lmt_limit_i),
      .step_i    (step_i),
      .valid_o   (cmd_valid_o[c]),
      .tgt_o     (cmd_tgt_o[c*2 +: 2]),
      .amt_o     (cmd_amt_o[c*STEP_W +: STEP_W])
    );
  end
endmodule

// File: rtl/gr_router_chk.sv
module gr_router_chk
  import gr_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int IDX_W  = 5,
  parameter int STEP_W = 3
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     auto_en_i,
  input logic [STEP_W-1:0]        step_i,
  input logic [NUM_CH*FLAG_W-1:0] ovl_i,
  input logic [NUM_CH-1:0]        cmd_valid_o,
  input logic [NUM_CH*2-1:0]      cmd_tgt_o,
  input logic [NUM_CH*STEP_W-1:0] cmd_amt_o
);
  // R2
  auto_off_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !auto_en_i |=> (cmd_valid_o == '0));

  // R12
  zero_step_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i == '0) |=> (cmd_valid_o == '0));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R3
    no_flag_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ovl_i[c*FLAG_W +: FLAG_W] == '0) |=> !cmd_valid_o[c]);

    // R4
    tgt_code_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cmd_valid_o[c] |-> (cmd_tgt_o[c*2 +: 2] != 2'd3));

    // R4
    lmt_flag_not_dig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ovl_i[c*FLAG_W + F_LMT_BIG] |=>
        (!cmd_valid_o[c] || cmd_tgt_o[c*2 +: 2] != TGT_DIG));

    // R9
    dig_only_to_dig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ovl_i[c*FLAG_W +: FLAG_W] == 4'b1000) |=>
        (!cmd_valid_o[c] || cmd_tgt_o[c*2 +: 2] == TGT_DIG));

    // R10
    amt_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cmd_valid_o[c] |-> (cmd_amt_o[c*STEP_W +: STEP_W] != '0));

    // R7
    amt_within_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      auto_en_i |=>
        (!cmd_valid_o[c] || cmd_amt_o[c*STEP_W +: STEP_W] <= $past(step_i)));
  end
endmodule

bind gr_router gr_router_chk #(.NUM_CH(NUM_CH), .IDX_W(IDX_W), .STEP_W(STEP_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .auto_en_i   (auto_en_i),
  .step_i      (step_i),
  .ovl_i       (ovl_i),
  .cmd_valid_o (cmd_valid_o),
  .cmd_tgt_o   (cmd_tgt_o),
  .cmd_amt_o   (cmd_amt_o)
);

// File: tb/gr_router_bench.sv
module gr_router_bench;
  localparam int NCH = 2;
  localparam int IW  = 3;
  localparam int SW  = 2;
  localparam int IMAX = (1 << IW) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             en;
  logic [SW-1:0]    step;
  logic [IW-1:0]    lim;
  logic [NCH*4-1:0] ovl;
  logic [NCH*IW-1:0] lmt, lpf, dig;
  logic [NCH-1:0]    vld;
  logic [NCH*2-1:0]  tgt;
  logic [NCH*SW-1:0] amt;

  int checks = 0;
  int fails  = 0;
  int exp_v[NCH], exp_t[NCH], exp_a[NCH];
  string exp_tag[NCH];

  always #4 clk = ~clk;

  gr_router #(.NUM_CH(NCH), .IDX_W(IW), .STEP_W(SW)) u_gr_router (
    .clk_i(clk), .rst_ni(rst_n), .auto_en_i(en), .step_i(step),
    .lmt_limit_i(lim), .ovl_i(ovl), .lmt_idx_i(lmt), .lpf_idx_i(lpf),
    .dig_idx_i(dig), .cmd_valid_o(vld), .cmd_tgt_o(tgt), .cmd_amt_o(amt)
  );

  function automatic int min2(int a, int b);
    return (a < b) ? a : b;
  endfunction

  // expected command from the requirements
  task automatic model(input int c, input int e, input int f, input int li,
                       input int lm, input int lp, input int dg, input int st);
    int t, room;
    string tag;
    t = 0; room = 0; tag = "R3";
    if (f[0]) begin
      if (li > 0) begin t = 0; room = li; tag = "R5"; end
      else begin t = 1; room = lp; tag = "R6"; end
    end else if (f[1] || f[2]) begin
      if (li > lm) begin t = 0; room = li - lm; tag = "R7"; end
      else begin t = 1; room = lp; tag = "R8"; end
    end else if (f[3]) begin
      t = 2; room = dg; tag = "R9";
    end
    if (f != 0 && (f & (f - 1)) != 0) tag = {tag, "/R4"};
    exp_a[c] = min2(room, st);
    if (f != 0 && st == 0) tag = "R12";
    else if (f != 0 && exp_a[c] == 0) tag = {tag, "/R10"};
    exp_v[c] = (e != 0 && f != 0 && exp_a[c] != 0) ? 1 : 0;
    if (e == 0) tag = "R2";
    exp_t[c] = t;
    exp_tag[c] = {tag, "/R11"};
  endtask

  task automatic check_ch(input int c);
    int av, at, aa;
    av = int'(vld[c]);
    at = int'(tgt[c*2 +: 2]);
    aa = int'(amt[c*SW +: SW]);
    checks++;
    if (av != exp_v[c] || (exp_v[c] == 1 && (at != exp_t[c] || aa != exp_a[c]))) begin
      fails++;
      $display("FAIL %s ch%0d: valid/tgt/amt actual %0d/%0d/%0d expected %0d/%0d/%0d",
               exp_tag[c], c, av, at, aa, exp_v[c], exp_t[c], exp_a[c]);
    end
  endtask

  task automatic apply(input int e, input int f0, input int li0, input int lp0,
                       input int dg0, input int f1, input int li1, input int lp1,
                       input int dg1, input int lm, input int st);
    en   = e[0];
    lim  = lm[IW-1:0];
    step = st[SW-1:0];
    ovl  = {f1[3:0], f0[3:0]};
    lmt  = {li1[IW-1:0], li0[IW-1:0]};
    lpf  = {lp1[IW-1:0], lp0[IW-1:0]};
    dig  = {dg1[IW-1:0], dg0[IW-1:0]};
    model(0, e, f0, li0, lm, lp0, dg0, st);
    model(1, e, f1, li1, lm, lp1, dg1, st);
    @(negedge clk);
    check_ch(0);
    check_ch(1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : stim
    en = 1'b1; step = '1; lim = '0; ovl = '1; lmt = '1; lpf = '1; dig = '1;
    repeat (3) @(negedge clk);
    // R1: held in reset with active flags
    checks++;
    if (vld !== '0) begin
      fails++;
      $display("FAIL R1 during reset: valid actual %0b expected 0", vld);
    end
    rst_n = 1'b1;
    ovl = '0;
    @(negedge clk);
    checks++;
    if (vld !== '0) begin
      fails++;
      $display("FAIL R1 after release: valid actual %0b expected 0", vld);
    end

    // R2: enable low with every kind of overload
    for (int f = 1; f < 16; f++)
      apply(0, f, 5, 3, 4, f, 2, 6, 1, 1, 3);

    // main sweep covering R3..R12
    for (int f = 0; f < 16; f++)
      for (int li = 0; li <= IMAX; li++)
        for (int lm = 0; lm <= IMAX; lm++)
          for (int st = 0; st < (1 << SW); st++)
            for (int k = 0; k < 3; k++) begin
              int lp, dg;
              lp = (k == 0) ? 0 : (k == 1) ? 2 : IMAX;
              dg = (li + lm + k) % (IMAX + 1);
              apply(1, f, li, lp, dg,
                    f ^ 5, IMAX - li, (lp + 3) % (IMAX + 1), IMAX - dg, lm, st);
            end

    // R1: reset asserted mid-stream clears a pending command
    apply(1, 1, 4, 2, 2, 8, 0, 0, 3, 0, 3);
    rst_n = 1'b0;
    #1;
    checks++;
    if (vld !== '0) begin
      fails++;
      $display("FAIL R1 async reset: valid actual %0b expected 0", vld);
    end
    rst_n = 1'b1;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule